// File: doc/BRIEF.md
# CPU Power Zone Sequencer

This block drives the power-domain controls of a cluster of processor cores. Each core owns one control word holding six control bits: clock enable, reset release, memory power, domain power, isolation and manual mode. While the block is idle, software may set or clear these bits directly through a small register port. A single hardware sequencer can also step them for one chosen core in a fixed order. During a power-up or power-down run it waits on the memory-power-good and domain-power-good status inputs of that core. A cycle counter bounds each of those waits.

A reset-configuration register holds one bit per core, and a set bit keeps that core in reset. A power-up run clears only the target core's bit, and a power-down run sets it again. Each core also has a pair of boot-address words, and the second word of the pair drives that core's start vector. The power switches and the cores themselves are outside the block and are seen only through the status inputs. A power-down request for core 0 is always refused.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, every control bit of every core is 0. All reset-configuration bits are 1. All boot words are 0. `busy`, `done` and `fault` are 0.
- R2: Power-up of a core whose alive status is 0 changes its control bits in this order: isolation 1, manual 1, domain power 1, memory power 1. It then waits for memory-good before setting clock enable 1, and waits for domain-good before setting isolation 0. Reset release 1 follows.
- R3: Power-down changes control bits in this order: manual 1 (no change if already set), reset release 0, clock enable 0, isolation 1, memory power 0. It then waits for memory-good to clear before setting domain power 0, and waits for domain-good to clear before the core's reset-configuration bit is set.
- R4: If a status wait lasts longer than `TMO_CYCLES`+1 cycles, `fault` goes to 1 and stays there until reset. `busy` drops, the sequence stops where it was, and later requests are ignored.
- R5: A power-down request for core 0 is refused. `busy` stays 0, no `done` pulse is produced, and no control bit changes.
- R6: Core c's control word is at byte address CTL_BASE+4*c. Its control bits are: bit0 clock enable, bit1 reset release, bit4 memory power, bit5 domain power, bit6 isolation, bit7 manual. Bits 2 and 3 read as 0. On read, bit31 shows alive status, bit29 memory-good and bit28 domain-good.
- R7: Core c's boot words are at BOOT_BASE+8*c and BOOT_BASE+8*c+4. Both words read back what was written. The word at +4 drives `boot_vec` for core c only.
- R8: The reset-configuration register is at RCFG_ADDR, with bit c for core c. A power-up run clears only the target core's bit, and a power-down run sets only that bit.
- R9: `busy` is 1 while a run is active. Requests and register writes made while busy are ignored. `done` is a one-cycle pulse at the end of a run.
- R10: A power-up request for a core whose alive status is already 1 changes no control bit. It only clears that core's reset-configuration bit, with `done` 2 cycles after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_up | input | 1 | Power-up request pulse |
| req_down | input | 1 | Power-down request pulse |
| req_core | input | CW | Core targeted by the request |
| sts_mem_good | input | N_CORES | Memory power good, per core |
| sts_dom_good | input | N_CORES | Domain power good, per core |
| sts_alive | input | N_CORES | Core is out of reset, per core |
| core_clk_en | output | N_CORES | Clock enable, per core |
| core_rst_rel | output | N_CORES | Reset release, per core |
| core_mem_pwr | output | N_CORES | Memory power on, per core |
| core_dom_pwr | output | N_CORES | Domain power request, per core |
| core_iso | output | N_CORES | Isolation active, per core |
| core_manual | output | N_CORES | Manual mode, per core |
| core_hold | output | N_CORES | Reset-configuration bits |
| boot_vec | output | 32*N_CORES | Start vector per core |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished pulse |
| fault | output | 1 | Status-wait timeout |

## Verification
The hardest condition to reach from the ports is a wait that expires. The power model has to keep a status input stuck while the sequencer sits in the wait. The bench runs with a small timeout parameter and pins memory-good low for one core, so the run stalls after memory power is raised. The bench then checks that the clock enable was never set, and that a fresh request is ignored. A second hard case is a request or write made in the middle of a run. The bench issues these a few cycles after an accepted power-up, while the core model is still delaying its good signals.

// File: rtl/cpz_pkg.sv
package cpz_pkg;
   localparam int B_CLK   = 0;
   localparam int B_RST   = 1;
   localparam int B_MEM   = 4;
   localparam int B_DOM   = 5;
   localparam int B_ISO   = 6;
   localparam int B_MAN   = 7;
   localparam int S_DOMG  = 28;
   localparam int S_MEMG  = 29;
   localparam int S_ALIVE = 31;
   localparam logic [7:0] CTL_MASK = 8'hF3;

   typedef enum logic [4:0] {
      ST_IDLE, U_ISO, U_MAN, U_DOM, U_MEM, U_WMEM, U_CLK, U_WDOM, U_UNISO,
      U_REL, D_MAN, D_RST, D_CLK, D_ISO, D_MEM, D_WMEM, D_DOM, D_WDOM,
      ST_HCLR, ST_HSET, ST_FAULT
   } seq_state_t;
endpackage

// File: rtl/cpz_timer.sv
module cpz_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int W = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("cpz_timer: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= W'(LIMIT);
      else if (run && cnt != 0) cnt <= cnt - 1'b1;
   end

   assign expired = run && (cnt == '0);
endmodule

// File: rtl/cpz_seq.sv
module cpz_seq
   import cpz_pkg::*;
#(
   parameter int N  = 4,
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_up,
   input  logic          req_down,
   input  logic [CW-1:0] req_core,
   input  logic [N-1:0]  alive,
   input  logic [N-1:0]  mem_good,
   input  logic [N-1:0]  dom_good,
   input  logic          tmo_expired,
   output logic [CW-1:0] core_sel,
   output logic          seq_we,
   output logic [7:0]    seq_mask,
   output logic          seq_val,
   output logic          hold_we,
   output logic          hold_val,
   output logic          tmo_load,
   output logic          tmo_run,
   output logic          busy,
   output logic          done,
   output logic          fault
);
   seq_state_t state;
   logic [CW-1:0] core_q;
   logic          done_q;
   logic          req_ok;
   logic          mg, dg;

   assign req_ok   = int'(req_core) < N;
   assign core_sel = core_q;
   assign mg       = mem_good[core_q];
   assign dg       = dom_good[core_q];

   // One control bit per step state.
   always_comb begin
      seq_we   = 1'b1;
      seq_mask = '0;
      seq_val  = 1'b1;
      tmo_load = 1'b0;
      unique case (state)
         U_ISO:   seq_mask[B_ISO] = 1'b1;
         U_MAN:   seq_mask[B_MAN] = 1'b1;
         U_DOM:   seq_mask[B_DOM] = 1'b1;
         U_MEM:   begin seq_mask[B_MEM] = 1'b1; tmo_load = 1'b1; end
         U_CLK:   begin seq_mask[B_CLK] = 1'b1; tmo_load = 1'b1; end
         U_UNISO: begin seq_mask[B_ISO] = 1'b1; seq_val = 1'b0; end
         U_REL:   seq_mask[B_RST] = 1'b1;
         D_MAN:   seq_mask[B_MAN] = 1'b1;
         D_RST:   begin seq_mask[B_RST] = 1'b1; seq_val = 1'b0; end
         D_CLK:   begin seq_mask[B_CLK] = 1'b1; seq_val = 1'b0; end
         D_ISO:   seq_mask[B_ISO] = 1'b1;
         D_MEM:   begin seq_mask[B_MEM] = 1'b1; seq_val = 1'b0; tmo_load = 1'b1; end
         D_DOM:   begin seq_mask[B_DOM] = 1'b1; seq_val = 1'b0; tmo_load = 1'b1; end
         default: seq_we = 1'b0;
      endcase
   end

   assign tmo_run  = (state == U_WMEM) || (state == U_WDOM) ||
                     (state == D_WMEM) || (state == D_WDOM);
   assign hold_we  = (state == ST_HCLR) || (state == ST_HSET);
   assign hold_val = (state == ST_HSET);
   assign busy     = (state != ST_IDLE) && (state != ST_FAULT);
   assign fault    = (state == ST_FAULT);
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         core_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE:
               if (req_up && req_ok) begin
                  core_q <= req_core;
                  state  <= alive[req_core] ? ST_HCLR : U_ISO;
               end else if (req_down && req_ok && req_core != '0) begin
                  core_q <= req_core;
                  state  <= D_MAN;
               end
            U_ISO:   state <= U_MAN;
            U_MAN:   state <= U_DOM;
            U_DOM:   state <= U_MEM;
            U_MEM:   state <= U_WMEM;
            U_WMEM:  if (mg) state <= U_CLK; else if (tmo_expired) state <= ST_FAULT;
            U_CLK:   state <= U_WDOM;
            U_WDOM:  if (dg) state <= U_UNISO; else if (tmo_expired) state <= ST_FAULT;
            U_UNISO: state <= U_REL;
            U_REL:   state <= ST_HCLR;
            D_MAN:   state <= D_RST;
            D_RST:   state <= D_CLK;
            D_CLK:   state <= D_ISO;
            D_ISO:   state <= D_MEM;
            D_MEM:   state <= D_WMEM;
            D_WMEM:  if (!mg) state <= D_DOM; else if (tmo_expired) state <= ST_FAULT;
            D_DOM:   state <= D_WDOM;
            D_WDOM:  if (!dg) state <= ST_HSET; else if (tmo_expired) state <= ST_FAULT;
            ST_HCLR, ST_HSET: begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: state <= ST_FAULT;
         endcase
      end
   end
endmodule

// File: rtl/cpz_regs.sv
module cpz_regs
   import cpz_pkg::*;
#(
   parameter int N         = 4,
   parameter int CW        = 2,
   parameter int ADDR_W    = 8,
   parameter int CTL_BASE  = 'h00,
   parameter int RCFG_ADDR = 'h20,
   parameter int BOOT_BASE = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic [31:0]       sw_wdata,
   output logic [31:0]       sw_rdata,
   input  logic              seq_we,
   input  logic [CW-1:0]     seq_core,
   input  logic [7:0]        seq_mask,
   input  logic              seq_val,
   input  logic              hold_we,
   input  logic              hold_val,
   input  logic [N-1:0]      mem_good,
   input  logic [N-1:0]      dom_good,
   input  logic [N-1:0]      alive,
   output logic [7:0]        ctl     [N],
   output logic [N-1:0]      hold,
   output logic [31:0]       boot_lo [N]
);
   logic [31:0] boot_hi [N];

   for (genvar c = 0; c < N; c++) begin : g_core
      localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_BASE + 4 * c);
      localparam logic [ADDR_W-1:0] A_BH  = ADDR_W'(BOOT_BASE + 8 * c);
      localparam logic [ADDR_W-1:0] A_BL  = ADDR_W'(BOOT_BASE + 8 * c + 4);
      logic [7:0]  ctl_q;
      logic [31:0] bh_q, bl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_q <= '0;
         end else if (seq_we && seq_core == CW'(c)) begin
            ctl_q <= (ctl_q & ~seq_mask) | (seq_val ? seq_mask : 8'h00);
         end else if (sw_we && sw_addr == A_CTL) begin
            ctl_q <= sw_wdata[7:0] & CTL_MASK;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bh_q <= '0;
            bl_q <= '0;
         end else if (sw_we) begin
            if (sw_addr == A_BH) bh_q <= sw_wdata;
            if (sw_addr == A_BL) bl_q <= sw_wdata;
         end
      end

      assign ctl[c]     = ctl_q;
      assign boot_hi[c] = bh_q;
      assign boot_lo[c] = bl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      hold <= '1;
      else if (hold_we)                                hold[seq_core] <= hold_val;
      else if (sw_we && sw_addr == ADDR_W'(RCFG_ADDR)) hold <= sw_wdata[N-1:0];
   end

   always_comb begin
      sw_rdata = '0;
      if (sw_addr == ADDR_W'(RCFG_ADDR)) sw_rdata = 32'(hold);
      for (int c = 0; c < N; c++) begin
         if (sw_addr == ADDR_W'(CTL_BASE + 4 * c)) begin
            sw_rdata          = 32'(ctl[c]);
            sw_rdata[S_ALIVE] = alive[c];
            sw_rdata[S_MEMG]  = mem_good[c];
            sw_rdata[S_DOMG]  = dom_good[c];
         end
         if (sw_addr == ADDR_W'(BOOT_BASE + 8 * c))     sw_rdata = boot_hi[c];
         if (sw_addr == ADDR_W'(BOOT_BASE + 8 * c + 4)) sw_rdata = boot_lo[c];
      end
   end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
   import cpz_pkg::*;
#(
   parameter int N_CORES    = 4,
   parameter int ADDR_W     = 8,
   parameter int CLK_HZ     = 100_000_000,
   parameter int WAIT_MS    = 500,
   parameter int TMO_CYCLES = CLK_HZ / 1000 * WAIT_MS,
   parameter int CTL_BASE   = 'h00,
   parameter int RCFG_ADDR  = 'h20,
   parameter int BOOT_BASE  = 'h40,
   localparam int CW        = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 req_up,
   input  logic                 req_down,
   input  logic [CW-1:0]        req_core,
   input  logic [N_CORES-1:0]   sts_mem_good,
   input  logic [N_CORES-1:0]   sts_dom_good,
   input  logic [N_CORES-1:0]   sts_alive,
   output logic [N_CORES-1:0]   core_clk_en,
   output logic [N_CORES-1:0]   core_rst_rel,
   output logic [N_CORES-1:0]   core_mem_pwr,
   output logic [N_CORES-1:0]   core_dom_pwr,
   output logic [N_CORES-1:0]   core_iso,
   output logic [N_CORES-1:0]   core_manual,
   output logic [N_CORES-1:0]   core_hold,
   output logic [32*N_CORES-1:0] boot_vec,
   output logic                 busy,
   output logic                 done,
   output logic                 fault
);
   if (N_CORES < 2 || N_CORES > 32) begin : g_bad_n
      $error("core_pwr_seq: N_CORES must be 2..32");
   end
   if (CTL_BASE + 4 * N_CORES > RCFG_ADDR || RCFG_ADDR >= BOOT_BASE ||
       BOOT_BASE + 8 * N_CORES > (1 << ADDR_W)) begin : g_bad_map
      $error("core_pwr_seq: register windows overlap or exceed ADDR_W");
   end
   if (TMO_CYCLES < 1) begin : g_bad_tmo
      $error("core_pwr_seq: TMO_CYCLES must be positive");
   end

   logic [CW-1:0] core_sel;
   logic          seq_we, seq_val, hold_we, hold_val;
   logic [7:0]    seq_mask;
   logic          tmo_load, tmo_run, tmo_expired;
   logic [7:0]    ctl     [N_CORES];
   logic [31:0]   boot_lo [N_CORES];

   cpz_seq #(.N(N_CORES), .CW(CW)) u_seq (
      .clk, .rst_n, .req_up, .req_down, .req_core,
      .alive(sts_alive), .mem_good(sts_mem_good), .dom_good(sts_dom_good),
      .tmo_expired, .core_sel, .seq_we, .seq_mask, .seq_val,
      .hold_we, .hold_val, .tmo_load, .tmo_run, .busy, .done, .fault
   );

   cpz_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
      .clk, .rst_n, .load(tmo_load), .run(tmo_run), .expired(tmo_expired)
   );

   cpz_regs #(
      .N(N_CORES), .CW(CW), .ADDR_W(ADDR_W), .CTL_BASE(CTL_BASE),
      .RCFG_ADDR(RCFG_ADDR), .BOOT_BASE(BOOT_BASE)
   ) u_regs (
      .clk, .rst_n, .sw_we(reg_we & ~busy), .sw_addr(reg_addr),
      .sw_wdata(reg_wdata), .sw_rdata(reg_rdata), .seq_we, .seq_core(core_sel),
      .seq_mask, .seq_val, .hold_we, .hold_val, .mem_good(sts_mem_good),
      .dom_good(sts_dom_good), .alive(sts_alive), .ctl, .hold(core_hold), .boot_lo
   );

   for (genvar c = 0; c < N_CORES; c++) begin : g_out
      assign core_clk_en[c]       = ctl[c][B_CLK];
      assign core_rst_rel[c]      = ctl[c][B_RST];
      assign core_mem_pwr[c]      = ctl[c][B_MEM];
      assign core_dom_pwr[c]      = ctl[c][B_DOM];
      assign core_iso[c]          = ctl[c][B_ISO];
      assign core_manual[c]       = ctl[c][B_MAN];
      assign boot_vec[32*c +: 32] = boot_lo[c];
   end
endmodule

// File: rtl/cpz_checker.sv
module cpz_checker #(
   parameter int N  = 4,
   parameter int CW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_up,
   input logic          req_down,
   input logic [CW-1:0] req_core,
   input logic          busy,
   input logic          done,
   input logic          fault,
   input logic [N-1:0]  core_clk_en,
   input logic [N-1:0]  core_iso,
   input logic [N-1:0]  core_hold,
   input logic [N-1:0]  mem_good,
   input logic [N-1:0]  dom_good
);
   for (genvar c = 0; c < N; c++) begin : g_c
      // R2
      clk_after_memgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(core_clk_en[c]) && busy) |-> mem_good[c]);
      // R2
      iso_drop_after_domgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(core_iso[c]) && busy) |-> dom_good[c]);
   end

   // R8
   hold_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($countones(core_hold ^ $past(core_hold)) <= 1));
   // R5
   core0_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !fault && req_down && !req_up && req_core == '0) |=> !busy);
   // R4
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (fault && !busy));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind core_pwr_seq cpz_checker #(.N(N_CORES), .CW(CW)) u_cpz_chk (
   .clk, .rst_n, .req_up, .req_down, .req_core, .busy, .done, .fault,
   .core_clk_en, .core_iso, .core_hold,
   .mem_good(sts_mem_good), .dom_good(sts_dom_good)
);

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int TMO = 20;
   localparam int WD  = 20000;

   logic clk = 0, rst_n = 0;
   logic reg_we = 0;
   logic [7:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic req_up = 0, req_down = 0;
   logic [1:0] req_core = 0;
   logic [N-1:0] mem_good, dom_good, alive;
   logic [N-1:0] clk_en, rst_rel, mem_pwr, dom_pwr, iso, manual, hold;
   logic [32*N-1:0] boot_vec;
   logic busy, done, fault;
   logic [N-1:0] stuck_mem = '0;
   logic [2:0] mem_d [N];
   logic [3:0] dom_d [N];

   int checks = 0, fails = 0, cyc = 0;
   logic [3:0] ev [32];
   int ev_n = 0;
   logic mon_on = 0;
   int mon_core = 1;
   logic [7:0] prev_ctl;

   always #(CLK_PERIOD / 2) clk = ~clk;

   core_pwr_seq #(.N_CORES(N), .TMO_CYCLES(TMO)) u_core_pwr_seq (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .req_up, .req_down, .req_core,
      .sts_mem_good(mem_good), .sts_dom_good(dom_good), .sts_alive(alive),
      .core_clk_en(clk_en), .core_rst_rel(rst_rel), .core_mem_pwr(mem_pwr),
      .core_dom_pwr(dom_pwr), .core_iso(iso), .core_manual(manual),
      .core_hold(hold), .boot_vec, .busy, .done, .fault
   );

   // Power model: memory good follows memory power by 3 cycles, domain good by 4.
   always_ff @(posedge clk) begin
      for (int c = 0; c < N; c++) begin
         mem_d[c] <= {mem_d[c][1:0], mem_pwr[c]};
         dom_d[c] <= {dom_d[c][2:0], dom_pwr[c]};
      end
   end
   for (genvar c = 0; c < N; c++) begin : g_model
      assign mem_good[c] = mem_d[c][2] & ~stuck_mem[c];
      assign dom_good[c] = dom_d[c][3];
   end
   assign alive = rst_rel;

   function automatic logic [7:0] ctl_of(int c);
      return {manual[c], iso[c], dom_pwr[c], mem_pwr[c], 2'b00, rst_rel[c], clk_en[c]};
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         for (int b = 0; b < 8; b++)
            if (ctl_of(mon_core)[b] != prev_ctl[b] && ev_n < 32) begin
               ev[ev_n] = {ctl_of(mon_core)[b], 3'(b)};
               ev_n++;
            end
      end
      prev_ctl = ctl_of(mon_core);
      if (cyc > WD) begin
         fails++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, WD);
         summary();
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input bit up, input int core);
      @(negedge clk);
      req_core = 2'(core); req_up = up; req_down = !up;
      @(negedge clk);
      req_up = 0; req_down = 0;
   endtask

   task automatic wait_done(input int lim, output bit seen);
      seen = 0;
      for (int i = 0; i < lim && !seen; i++) begin
         if (done) seen = 1;
         else @(negedge clk);
      end
   endtask

   task automatic start_mon(input int c);
      @(negedge clk);
      mon_core = c; ev_n = 0; mon_on = 1;
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      chk(clk_en == 0 && rst_rel == 0 && mem_pwr == 0 && dom_pwr == 0 && iso == 0 && manual == 0,
          "R1 control bits", {clk_en, rst_rel, mem_pwr, dom_pwr, iso, manual}, 0);
      chk(hold == 4'hF, "R1 hold bits", hold, 4'hF);
      chk(boot_vec == 0 && !busy && !done && !fault, "R1 boot/flags", {busy, done, fault}, 0);
      rd(8'h20, d);
      chk(d == 32'hF, "R1 rcfg read", d, 32'hF);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(8'h0C, 32'hFF);
      repeat (6) @(negedge clk);
      rd(8'h0C, d);
      chk(d == 32'hB00000F3, "R6 core3 word with status", d, 32'hB00000F3);
      chk(clk_en == 4'b1000 && manual == 4'b1000, "R6 core3 decode", clk_en, 4'b1000);
      wr(8'h0C, 32'h0);
      repeat (6) @(negedge clk);
      rd(8'h0C, d);
      chk(d == 0, "R6 core3 cleared", d, 0);
      wr(8'h50, 32'h0);
      wr(8'h54, 32'h8000_1000);
      rd(8'h54, d);
      chk(d == 32'h8000_1000, "R7 boot word readback", d, 32'h8000_1000);
      chk(boot_vec == {32'h0, 32'h8000_1000, 64'h0}, "R7 boot_vec core2 only",
          boot_vec[95:64], 32'h8000_1000);
      rd(8'h50, d);
      chk(d == 0, "R7 high word", d, 0);
   endtask

   task automatic t_power_up();
      bit seen;
      logic [31:0] d;
      logic [3:0] exp_up [7] = '{4'hE, 4'hF, 4'hD, 4'hC, 4'h8, 4'h6, 4'h9};
      start_mon(1);
      pulse(1, 1);
      chk(busy, "R9 busy after accept", busy, 1);
      // R9: request and write during the run are dropped
      pulse(1, 2);
      wr(8'h08, 32'h01);
      wait_done(200, seen);
      chk(seen, "R2 power-up done", seen, 1);
      @(negedge clk);
      mon_on = 0;
      chk(ev_n == 7, "R2 event count", ev_n, 7);
      for (int i = 0; i < 7; i++)
         chk(ev[i] == exp_up[i], "R2 step order", ev[i], exp_up[i]);
      chk(hold == 4'b1101, "R8 only core1 released", hold, 4'b1101);
      repeat (10) @(negedge clk);
      chk(!busy && clk_en[2] == 0 && hold[2], "R9 ignored while busy", {busy, clk_en[2]}, 0);
      rd(8'h08, d);
      chk(d[7:0] == 0, "R9 write dropped", d[7:0], 0);
   endtask

   task automatic t_skip();
      bit seen;
      wr(8'h20, 32'hF);
      start_mon(1);
      pulse(1, 1);
      wait_done(2, seen);
      chk(seen, "R10 fast done", seen, 1);
      @(negedge clk);
      mon_on = 0;
      chk(ev_n == 0, "R10 no control change", ev_n, 0);
      chk(hold == 4'b1101, "R10 hold cleared", hold, 4'b1101);
   endtask

   task automatic t_power_down();
      bit seen;
      logic [3:0] exp_dn [5] = '{4'h1, 4'h0, 4'hE, 4'h4, 4'h5};
      start_mon(1);
      pulse(0, 1);
      wait_done(200, seen);
      chk(seen, "R3 power-down done", seen, 1);
      @(negedge clk);
      mon_on = 0;
      chk(ev_n == 5, "R3 event count", ev_n, 5);
      for (int i = 0; i < 5; i++)
         chk(ev[i] == exp_dn[i], "R3 step order", ev[i], exp_dn[i]);
      chk(hold == 4'hF, "R8 core1 held again", hold, 4'hF);
      chk(manual[1], "R3 manual kept", manual[1], 1);
   endtask

   task automatic t_core0();
      logic [31:0] d;
      bit saw = 0;
      wr(8'h00, 32'hF3);
      pulse(0, 0);
      for (int i = 0; i < 8; i++) begin
         if (busy || done) saw = 1;
         @(negedge clk);
      end
      chk(!saw, "R5 no busy/done", saw, 0);
      rd(8'h00, d);
      chk(d[7:0] == 8'hF3 && hold[0], "R5 core0 unchanged", d[7:0], 8'hF3);
   endtask

   task automatic t_timeout();
      bit f = 0;
      stuck_mem[2] = 1;
      pulse(1, 2);
      for (int i = 0; i < 200 && !f; i++) begin
         if (fault) f = 1;
         else @(negedge clk);
      end
      chk(f, "R4 fault raised", f, 1);
      chk(!busy && mem_pwr[2] && !clk_en[2], "R4 stopped before clock",
          {busy, mem_pwr[2], clk_en[2]}, 3'b010);
      pulse(1, 3);
      repeat (5) @(negedge clk);
      chk(fault && !busy && !iso[3], "R4 later request ignored", {fault, busy, iso[3]}, 3'b100);
   endtask

   initial begin
      for (int c = 0; c < N; c++) begin mem_d[c] = 0; dom_d[c] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset_state();
      t_regmap();
      t_power_up();
      t_skip();
      t_power_down();
      t_core0();
      t_timeout();
      summary();
   end
endmodule